// File: doc/BRIEF.md
# I2C Master Receive Engine

This block is the receive half of an I2C bus master. The address phase has already been handled elsewhere. A one-cycle arm pulse then tells the engine that it owns the bus, and it holds SCL low. Each word is paced by the host. The host programs a 3-bit word-length code and an acknowledge enable, and each read strobe on the receive buffer launches one word. The engine releases SCL, clocks the word in MSB first and optionally clocks an acknowledge bit. At the end of the word it pulses an interrupt, drops a pending flag and holds SCL low again until the next buffer read.

Reception is shut down in two steps. First, the host clears the acknowledge enable before the read that fetches the last word, so that word is clocked without an acknowledge clock. Second, the host programs a 1-bit length with acknowledge still off and reads the buffer once more. The engine then sends a single clock with SDA released, which the slave sees as a negative acknowledge. It raises the interrupt and follows with a stop condition, which returns the bus to the free state.

SCL and SDA are modelled as open-drain enables (1 means pull low) with separate line inputs. Phase lengths come from two run-time counts of system clocks. The low phase count must be at least 2 so that SDA can settle while SCL is low. The line inputs are taken as already synchronous to the system clock.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, pin is 1, irq is 0 and busy is 0.
- R2: An rx_arm pulse while idle makes busy 1, pin 0 and scl_oe 1 from the next cycle on. An rx_arm pulse while busy has no effect.
- R3: A buf_rd strobe while SCL is held sets pin to 1 on the next cycle and clocks a word. The word has 8 data bits when the length code is 000, and otherwise as many data bits as the code value (1 to 7). Every bit spends t_low cycles with scl_oe 1, then t_high cycles with scl_oe 0.
- R4: Each data bit is sampled from sda_in in the first cycle of its high phase in which scl_in is 1, MSB first. At word end, buf_data holds the received bits right-justified, with the unused upper bits 0.
- R5: With acknowledge enabled, one extra clock follows the data bits, and sda_oe is 1 during it. With acknowledge disabled there is no extra clock, and sda_oe stays 0 through the word.
- R6: At the end of a word, irq is 1 for exactly one cycle and pin becomes 0 at the same time. scl_oe then stays 1 until the next accepted buf_rd.
- R7: A buf_rd strobe while a word is being clocked does not change the SCL/SDA timing of that word.
- R8: A word with length code 001 and acknowledge disabled is the closing transfer. After its interrupt, SCL is held low for t_low cycles while sda_oe goes to 1. SCL is then released for t_high cycles. Finally SDA is released with SCL high, busy drops to 0 and pin returns to 1.
- R9: sda_oe changes only while SCL has been driven low in the previous cycle. The single exception is the release that completes a stop condition.
- R10: While scl_in is 0 during a high phase (a slave stretching the clock), the high-phase count does not advance and no bit is sampled.
- R11: A cfg_wr during a word updates the stored length code and acknowledge enable. The new values take effect at the next accepted buf_rd, not on the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_arm | input | 1 | Address phase done; take the bus and hold SCL low |
| cfg_wr | input | 1 | Store cfg_count and cfg_ack |
| cfg_count | input | 3 | Word-length code (000 = 8 bits) |
| cfg_ack | input | 1 | Clock an acknowledge bit after the data bits |
| buf_rd | input | 1 | Host read strobe of the receive buffer |
| buf_data | output | 8 | Last received word, right-justified |
| pin | output | 1 | 0 while a finished word awaits a read |
| irq | output | 1 | One-cycle end-of-word interrupt pulse |
| busy | output | 1 | Engine owns the bus |
| t_low | input | 8 | SCL low phase length in system clocks (at least 2) |
| t_high | input | 8 | SCL high phase length in system clocks |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
A wrong slot counter or a wrong word-length decode changes the number of SCL pulses. That shows up within one phase length as an SCL level that differs from the expected per-cycle pattern. A stale acknowledge or closing flag appears as a wrong sda_oe level in the first low phase after the data bits, or as a missing stop sequence, well before the next buffer read. A mistimed sample point or a broken stretch counter only becomes visible on buf_data at word end. Extended high phases and word lengths below eight are therefore checked against the captured value, with the total word duration also counted.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned CW = $clog2(DW);
  localparam int unsigned SW = $clog2(DW + 2);

  typedef logic [CW-1:0] len_code_t;
  typedef logic [SW-1:0] slot_t;
  typedef logic [DW-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_HOLD      = 3'd1,
    ST_LOW       = 3'd2,
    ST_HIGH      = 3'd3,
    ST_STOP_LOW  = 3'd4,
    ST_STOP_HIGH = 3'd5
  } rx_state_e;

  // Data bits in a word: the all-zero code means a full word.
  function automatic slot_t bits_in_word(len_code_t code);
    return (code == '0) ? slot_t'(DW) : slot_t'(code);
  endfunction

  // Clock pulses in a word: data bits plus an optional acknowledge clock.
  function automatic slot_t slots_in_word(len_code_t code, logic ack);
    return bits_in_word(code) + slot_t'(ack);
  endfunction

  // A single bit without acknowledge is the negative-acknowledge transfer.
  function automatic logic is_closing(len_code_t code, logic ack);
    return (code == len_code_t'(1)) && !ack;
  endfunction

  function automatic logic drives_scl(rx_state_e st);
    return (st == ST_HOLD) || (st == ST_LOW) || (st == ST_STOP_LOW);
  endfunction

  // SDA level the engine wants while SCL is low in the given state.
  function automatic logic sda_target(rx_state_e st, logic ack_slot);
    case (st)
      ST_LOW:       return ack_slot;
      ST_STOP_LOW:  return 1'b1;
      ST_STOP_HIGH: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_rx_phase_timer.sv
module i2c_rx_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] len,
  output logic          expire,
  output logic          at_zero
);

  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
  assign at_zero  = (cnt == '0);
  assign expire   = run && (cnt_next >= {1'b0, len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || expire) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt_next[TW-1:0];
    end
  end

endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic          capture,
  output logic [DW-1:0] word
);

  logic [DW-1:0] sr;
  logic [DW-1:0] sr_next;

  assign sr_next = shift_en ? {sr[DW-2:0], bit_in} : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      word <= '0;
    end else begin
      if (clr) sr <= '0;
      else     sr <= sr_next;
      if (capture) word <= sr_next;
    end
  end

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm,
  input  logic      rd,
  input  len_code_t code,
  input  logic      ack_en,
  input  logic      scl_high,
  input  logic      tmr_expire,
  output rx_state_e state,
  output logic      ack_slot,
  output logic      rd_accept,
  output logic      word_end,
  output logic      tmr_run,
  output logic      tmr_clr,
  output logic      pin,
  output logic      irq
);

  rx_state_e st;
  slot_t     slot;
  slot_t     total;
  slot_t     nbits;
  logic      ack_l;
  logic      closing_l;
  logic      pin_q;
  logic      irq_q;
  logic      last_slot;

  assign last_slot = (slot == total - slot_t'(1));
  assign rd_accept = (st == ST_HOLD) && rd;
  assign word_end  = (st == ST_HIGH) && tmr_expire && last_slot;
  assign ack_slot  = ack_l && (slot == nbits);
  assign tmr_clr   = (st == ST_IDLE) || (st == ST_HOLD);
  assign state     = st;
  assign pin       = pin_q;
  assign irq       = irq_q;

  always_comb begin
    case (st)
      ST_LOW, ST_STOP_LOW:   tmr_run = 1'b1;
      ST_HIGH, ST_STOP_HIGH: tmr_run = scl_high;
      default:               tmr_run = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      slot      <= '0;
      total     <= '0;
      nbits     <= '0;
      ack_l     <= 1'b0;
      closing_l <= 1'b0;
      pin_q     <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (arm) begin
            st    <= ST_HOLD;
            pin_q <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (rd) begin
            pin_q     <= 1'b1;
            slot      <= '0;
            total     <= slots_in_word(code, ack_en);
            nbits     <= bits_in_word(code);
            ack_l     <= ack_en;
            closing_l <= is_closing(code, ack_en);
            st        <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tmr_expire) st <= ST_HIGH;
        end
        ST_HIGH: begin
          if (tmr_expire) begin
            if (last_slot) begin
              irq_q <= 1'b1;
              pin_q <= 1'b0;
              st    <= closing_l ? ST_STOP_LOW : ST_HOLD;
            end else begin
              slot <= slot + slot_t'(1);
              st   <= ST_LOW;
            end
          end
        end
        ST_STOP_LOW: begin
          if (tmr_expire) st <= ST_STOP_HIGH;
        end
        ST_STOP_HIGH: begin
          if (tmr_expire) begin
            st    <= ST_IDLE;
            pin_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
  import i2c_rx_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_arm,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_ack,
  input  logic          buf_rd,
  output logic [DW-1:0] buf_data,
  output logic          pin,
  output logic          irq,
  output logic          busy,
  input  logic [TW-1:0] t_low,
  input  logic [TW-1:0] t_high,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);

  len_code_t code_q;
  logic      ack_q;
  rx_state_e st;
  logic      ack_slot;
  logic      rd_accept;
  logic      word_end;
  logic      sample_evt;
  logic      tmr_run;
  logic      tmr_clr;
  logic      tmr_expire;
  logic      tmr_zero;
  logic      sda_q;
  logic [TW-1:0] phase_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ack_q  <= 1'b0;
    end else if (cfg_wr) begin
      code_q <= cfg_count;
      ack_q  <= cfg_ack;
    end
  end

  assign phase_len = ((st == ST_HIGH) || (st == ST_STOP_HIGH)) ? t_high : t_low;

  i2c_rx_phase_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .len     (phase_len),
    .expire  (tmr_expire),
    .at_zero (tmr_zero)
  );

  i2c_rx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (rx_arm),
    .rd         (buf_rd),
    .code       (code_q),
    .ack_en     (ack_q),
    .scl_high   (scl_in),
    .tmr_expire (tmr_expire),
    .state      (st),
    .ack_slot   (ack_slot),
    .rd_accept  (rd_accept),
    .word_end   (word_end),
    .tmr_run    (tmr_run),
    .tmr_clr    (tmr_clr),
    .pin        (pin),
    .irq        (irq)
  );

  // Sample point: first cycle of a data-bit high phase with the line seen high.
  assign sample_evt = (st == ST_HIGH) && scl_in && tmr_zero && !ack_slot;

  i2c_rx_shifter #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rd_accept),
    .shift_en (sample_evt),
    .bit_in   (sda_in),
    .capture  (word_end),
    .word     (buf_data)
  );

  assign scl_oe = drives_scl(st);
  assign busy   = (st != ST_IDLE);

  // SDA moves only while SCL is already held low, or when idle (stop release).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b0;
    end else if (scl_oe || (st == ST_IDLE)) begin
      sda_q <= sda_target(st, ack_slot);
    end
  end

  assign sda_oe = sda_q;

endmodule

// File: rtl/i2c_rx_master_chk.sv
module i2c_rx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_in,
  input logic pin,
  input logic irq,
  input logic busy,
  input logic rx_arm,
  input logic rd_accept,
  input logic sample_evt,
  input logic word_end
);

  AST_SDA_MOVES_UNDER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(scl_oe)) |-> (!sda_oe && !busy)) else $error("sda edge with scl high"); // R9

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("irq longer than one cycle"); // R6

  AST_IRQ_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (scl_oe && !pin)) else $error("irq without scl hold"); // R6

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (pin && busy)) else $error("read did not set pin"); // R3

  AST_ARM_SEIZES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_arm && !busy) |=> (scl_oe && !pin && busy)) else $error("arm did not seize bus"); // R2

  AST_SAMPLE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (scl_in && !scl_oe)) else $error("sample while scl low"); // R10

  AST_WORD_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> scl_in) else $error("word ended during stretch"); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && pin)) else $error("idle bus driven"); // R8

endmodule

bind i2c_rx_master i2c_rx_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .scl_in     (scl_in),
  .pin        (pin),
  .irq        (irq),
  .busy       (busy),
  .rx_arm     (rx_arm),
  .rd_accept  (rd_accept),
  .sample_evt (sample_evt),
  .word_end   (word_end)
);

// File: tb/tb_i2c_rx_master.sv
module tb_i2c_rx_master;

  localparam int TL = 3;
  localparam int TH = 2;

  typedef struct packed {
    logic scl;
    logic want;
    logic pin;
    logic irq;
    logic busy;
  } exp_t;

  localparam exp_t IDLE_E = '{scl: 1'b0, want: 1'b0, pin: 1'b1, irq: 1'b0, busy: 1'b0};
  localparam exp_t HOLD_E = '{scl: 1'b1, want: 1'b0, pin: 1'b0, irq: 1'b0, busy: 1'b1};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       rx_arm = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_count = 3'd0;
  logic       cfg_ack = 1'b0;
  logic       buf_rd = 1'b0;
  logic [7:0] buf_data;
  logic       pin, irq, busy, scl_oe, sda_oe;
  logic [7:0] t_low = 8'(TL);
  logic [7:0] t_high = 8'(TH);

  // Bus and slave model
  int   fall_cnt = 0;
  int   base = 0;
  int   cur_n = 8;
  logic [7:0] pat = 8'h00;
  int   stretch_used = 0;
  int   stretch_total = 0;
  logic prev_scl = 1'b1;
  logic slave_bit;
  logic scl_line, sda_line;

  assign scl_line = !scl_oe && !(stretch_used < stretch_total);
  always_comb begin
    int idx;
    idx = fall_cnt - base;
    slave_bit = (idx >= 0 && idx < cur_n) ? pat[cur_n - 1 - idx] : 1'b1;
  end
  assign sda_line = !sda_oe && slave_bit;

  always @(posedge clk) begin
    prev_scl <= scl_line;
    if (prev_scl && !scl_line) fall_cnt <= fall_cnt + 1;
    if (!scl_oe && (stretch_used < stretch_total)) stretch_used <= stretch_used + 1;
  end

  i2c_rx_master dut (
    .clk(clk), .rst_n(rst_n), .rx_arm(rx_arm), .cfg_wr(cfg_wr),
    .cfg_count(cfg_count), .cfg_ack(cfg_ack), .buf_rd(buf_rd),
    .buf_data(buf_data), .pin(pin), .irq(irq), .busy(busy),
    .t_low(t_low), .t_high(t_high), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  bit   cmp_on = 1;
  exp_t q[$];
  exp_t rest = IDLE_E;
  logic exp_sda = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference schedule
  task automatic compare();
    exp_t e;
    if (!rst_n || !cmp_on) begin
      exp_sda = 1'b0;
      return;
    end
    if (q.size() > 0) e = q.pop_front();
    else e = rest;
    chk(scl_oe == e.scl, "R3 scl_oe", scl_oe, e.scl);
    chk(sda_oe == exp_sda, "R5/R9 sda_oe", sda_oe, exp_sda);
    chk(pin == e.pin, "R6 pin", pin, e.pin);
    chk(irq == e.irq, "R6 irq", irq, e.irq);
    chk(busy == e.busy, "R8 busy", busy, e.busy);
    if (e.scl || !e.busy) exp_sda = e.want;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
  endtask

  task automatic do_cfg(input logic [2:0] code, input logic ack);
    cfg_wr = 1'b1; cfg_count = code; cfg_ack = ack;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic plan_word(input int n, input bit a, input bit fin);
    q.push_back(HOLD_E);
    for (int s = 0; s < n + int'(a); s++) begin
      for (int c = 0; c < TL; c++) q.push_back('{1'b1, s == n, 1'b1, 1'b0, 1'b1});
      for (int c = 0; c < TH; c++) q.push_back('{1'b0, s == n, 1'b1, 1'b0, 1'b1});
    end
    if (fin) begin
      for (int c = 0; c < TL; c++) q.push_back('{1'b1, 1'b1, 1'b0, c == 0, 1'b1});
      for (int c = 0; c < TH; c++) q.push_back('{1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
      rest = IDLE_E;
    end else begin
      q.push_back('{1'b1, 1'b0, 1'b0, 1'b1, 1'b1});
      rest = HOLD_E;
    end
  endtask

  // One word; poke > 0 issues a buf_rd and cfg_wr that many cycles into the word.
  task automatic do_read(input int code, input bit a, input logic [7:0] p,
                         input int poke, input logic [2:0] pcode, input logic pack,
                         input string tag);
    int n;
    int k;
    logic [7:0] want;
    n = (code == 0) ? 8 : code;
    pat = p; cur_n = n; base = fall_cnt;
    plan_word(n, a, (code == 1) && !a);
    buf_rd = 1'b1;
    tick();
    buf_rd = 1'b0;
    k = 0;
    while (q.size() > 0) begin
      tick();
      k++;
      if (poke > 0 && k == poke) begin
        buf_rd = 1'b1; cfg_wr = 1'b1; cfg_count = pcode; cfg_ack = pack;
        tick();
        buf_rd = 1'b0; cfg_wr = 1'b0;
      end
    end
    tick();
    want = (n == 8) ? p : (p & 8'((1 << n) - 1));
    chk(buf_data == want, tag, buf_data, want);
  endtask

  initial begin
    repeat (3) tick();
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset lines", {scl_oe, sda_oe}, 0);
    chk(pin == 1'b1 && irq == 1'b0 && busy == 1'b0, "R1 reset flags", {pin, irq, busy}, 3'b100);
    rst_n = 1'b1;
    repeat (2) tick();

    // R2: arm takes the bus
    rx_arm = 1'b1;
    q.push_back(IDLE_E);
    rest = HOLD_E;
    tick();
    rx_arm = 1'b0;
    repeat (3) tick();
    chk(busy && !pin && scl_oe, "R2 arm holds scl", {busy, pin, scl_oe}, 3'b101);

    // R3/R4/R5: full word with acknowledge
    do_cfg(3'd0, 1'b1);
    do_read(0, 1'b1, 8'hA5, 0, 3'd0, 1'b0, "R4 word A5");
    repeat (3) tick();

    // R7/R11: stray read and config write mid-word do not disturb it
    do_read(0, 1'b1, 8'h3C, 10, 3'd5, 1'b1, "R7 R11 word 3C after stray read");
    repeat (2) tick();

    // R3/R11: 5-bit word using the config written mid-word
    do_read(5, 1'b1, 8'hF3, 0, 3'd0, 1'b0, "R3 R11 five-bit word");
    repeat (2) tick();

    // R2: arm while busy is ignored
    rx_arm = 1'b1;
    tick();
    rx_arm = 1'b0;
    repeat (4) tick();
    chk(busy && !pin && scl_oe, "R2 arm ignored while busy", {busy, pin, scl_oe}, 3'b101);

    // R10: clock stretching on the first high phase
    begin
      int cnt;
      bit got;
      int expect_cnt;
      do_cfg(3'd0, 1'b1);
      cmp_on = 0;
      pat = 8'h81; cur_n = 8; base = fall_cnt;
      stretch_total = stretch_used + 5;
      buf_rd = 1'b1;
      cnt = 0; got = 0;
      while (!got && cnt < 2000) begin
        @(negedge clk);
        cnt++;
        if (irq) got = 1;
        @(posedge clk);
        #1;
        buf_rd = 1'b0;
      end
      expect_cnt = 2 + 9 * (TL + TH) + 5;
      chk(cnt == expect_cnt, "R10 stretched word length", cnt, expect_cnt);
      repeat (3) tick();
      chk(buf_data == 8'h81, "R10 R4 stretched word data", buf_data, 8'h81);
      rest = HOLD_E;
      cmp_on = 1;
      repeat (2) tick();
    end

    // R5: last data word without acknowledge clock
    do_cfg(3'd0, 1'b0);
    do_read(0, 1'b0, 8'h6E, 0, 3'd0, 1'b0, "R5 no-ack word 6E");
    repeat (2) tick();

    // R8: one-bit NACK transfer then stop
    do_cfg(3'd1, 1'b0);
    do_read(1, 1'b0, 8'h01, 0, 3'd0, 1'b0, "R8 closing bit");
    repeat (3) tick();
    chk(!busy && pin && !scl_oe && !sda_oe, "R8 bus free after stop",
        {busy, pin, scl_oe, sda_oe}, 4'b0100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end

endmodule